// File: doc/BRIEF.md
# Read-Only Serial Sensor Host Controller

This block is the host side of a three-wire serial link to a sensor that only talks back. The wires are a serial clock, an active-low select and a single sensor-to-host data line. There is no data line from host to sensor, so the sensor is controlled by the select line alone. A local requester asks for one of two operations. A start operation wakes a sleeping sensor: one dummy byte is clocked in, and the select line is held low for a guaranteed minimum time before it is released. The rising edge of the select line starts the conversion. A data read clocks in two, three or four bytes and then releases the select line.

When an operation finishes, the controller pulses a done strobe. The strobe carries the byte count and whether the operation was a start. After a read, it also presents the captured bytes left-aligned in a 32-bit word, and a status code decoded from the top two bits of the first byte. A sensor in free-running mode needs no start operation, and a build for that mode refuses starts. A sensor in triggered mode sleeps after each update, so the requester issues a start before each read.

Top module: `spi_sensor_host`

## Requirements
- R1: After reset and between operations, `ss_n` is high, `sclk` is low, `busy` is low and `done` is low.
- R2: While `ss_n` is low, `sclk` toggles every `CLK_DIV` system clocks. The bus makes eight rising `sclk` edges per byte. `miso` is sampled MSB first on each rising edge.
- R3: A start request (`req_start`=1, `TRIGGERED`=1) clocks one dummy byte. It holds `ss_n` low for at least `MIN_LOW_CYC` clocks, and for exactly `MIN_LOW_CYC` clocks when the byte finishes sooner. It completes with `done_start`=1 and `done_nbytes`=1, and leaves `rd_data` and `status` unchanged.
- R4: A read request (`req_start`=0) clocks 2 bytes for `req_len`=00, 3 for 01 and 4 for 10 or 11. It completes with `done_start`=0 and `done_nbytes` equal to that count.
- R5: `rd_data` holds the first byte received in bits [31:24] and later bytes below it. Byte positions that were not read are zero.
- R6: `status` is decoded from the first byte's bits [7:6] (`rd_data[31:30]`): 00 gives 00 (fresh), 10 gives 10 (stale), 11 gives 11 (fault), and the unused code 01 is also reported as 11.
- R7: `done` is a one-cycle pulse. It is issued in the same cycle that `ss_n` returns high.
- R8: `busy` is high from the cycle after a request is accepted until `done`. A request made while `busy` is high is dropped and causes no later bus activity.
- R9: With `TRIGGERED`=0, a start request is dropped: `ss_n` stays high and no `done` is produced. Reads behave as in R4 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_start | input | 1 | 1 = start conversion, 0 = data read |
| req_len | input | 2 | Read length code: 00 = 2, 01 = 3, 1x = 4 bytes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| done_start | output | 1 | Finished operation was a start |
| done_nbytes | output | 3 | Bytes clocked by the finished operation |
| rd_data | output | 32 | Left-aligned read data |
| status | output | 2 | Decoded sensor status of the last read |
| sclk | output | 1 | Serial clock, idles low |
| ss_n | output | 1 | Active-low sensor select |
| miso | input | 1 | Sensor-to-host data |

## Verification
The bench sweeps every status code against every read length. A wrong alignment would leave the first byte in the low bits, and a wrong mask would leak stale bits into unused byte positions. The start operation uses a dummy byte shorter than the minimum low time. A design that released the select line when the byte ended would show a shortened low pulse, and one that overwrote the read data during a start would lose the previous result. A second request made during a transfer must produce no second done and no extra clock edges. A free-running build must keep the select line high on a start request.

// File: rtl/spi_sensor_host.sv
module spi_sensor_host #(
  parameter int CLK_DIV     = 4,
  parameter int MIN_LOW_CYC = 1600,
  parameter int TRIGGERED   = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_start,
  input  logic [1:0]  req_len,
  output logic        busy,
  output logic        done,
  output logic        done_start,
  output logic [2:0]  done_nbytes,
  output logic [31:0] rd_data,
  output logic [1:0]  status,
  output logic        sclk,
  output logic        ss_n,
  input  logic        miso
);
  localparam int DW = $clog2(CLK_DIV) + 1;
  localparam int LW = $clog2(MIN_LOW_CYC + 1) + 1;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_HOLD} st_t;
  st_t st;

  logic          op_start;
  logic [2:0]    nb;
  logic [DW-1:0] div;
  logic [5:0]    bitcnt;
  logic [31:0]   sh;
  logic [LW-1:0] lowcnt;
  logic          sclk_q, ss_q;
  logic [2:0]    req_nb;
  logic [31:0]   aligned;
  logic [1:0]    raw;

  wire accept   = req_valid && st == S_IDLE && (!req_start || TRIGGERED != 0);
  wire tick     = div == DW'(CLK_DIV - 1);
  wire last_bit = bitcnt == {nb, 3'b000};
  wire low_ok   = !op_start || lowcnt >= LW'(MIN_LOW_CYC - 1);

  always_comb begin
    if (req_start)         req_nb = 3'd1;
    else if (req_len == 0) req_nb = 3'd2;
    else if (req_len == 1) req_nb = 3'd3;
    else                   req_nb = 3'd4;
  end

  always_comb begin
    case (nb)
      3'd2:    aligned = {sh[15:0], 16'h0};
      3'd3:    aligned = {sh[23:0], 8'h0};
      default: aligned = sh;
    endcase
  end

  assign raw = aligned[31:30];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      op_start    <= 1'b0;
      nb          <= 3'd0;
      div         <= '0;
      bitcnt      <= '0;
      sh          <= '0;
      lowcnt      <= '0;
      sclk_q      <= 1'b0;
      ss_q        <= 1'b1;
      done        <= 1'b0;
      done_start  <= 1'b0;
      done_nbytes <= 3'd0;
      rd_data     <= '0;
      status      <= 2'b00;
    end else begin
      done <= 1'b0;
      if (st != S_IDLE && lowcnt != '1) lowcnt <= lowcnt + 1'b1;
      case (st)
        S_IDLE: if (accept) begin
          st       <= S_XFER;
          op_start <= req_start;
          nb       <= req_nb;
          div      <= '0;
          bitcnt   <= '0;
          sh       <= '0;
          lowcnt   <= '0;
          ss_q     <= 1'b0;
        end
        S_XFER: begin
          div <= tick ? '0 : div + 1'b1;
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              sh     <= {sh[30:0], miso};
              bitcnt <= bitcnt + 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (last_bit) st <= S_HOLD;
            end
          end
        end
        S_HOLD: if (low_ok) begin
          st          <= S_IDLE;
          ss_q        <= 1'b1;
          done        <= 1'b1;
          done_start  <= op_start;
          done_nbytes <= nb;
          if (!op_start) begin
            rd_data <= aligned;
            status  <= (raw == 2'b01) ? 2'b11 : raw;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy = st != S_IDLE;
  assign sclk = sclk_q;
  assign ss_n = ss_q;
endmodule

// File: rtl/spi_sensor_host_chk.sv
module spi_sensor_host_chk #(
  parameter int MIN_LOW_CYC = 1600,
  parameter int TRIGGERED   = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       ss_n,
  input logic       busy,
  input logic       done,
  input logic       done_start,
  input logic [2:0] done_nbytes,
  input logic [1:0] status
);
  logic [31:0] low_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_q <= '0;
    else if (!ss_n) low_q <= low_q + 1;
    else            low_q <= '0;
  end

  a_r1_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !sclk);
  a_r3_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_start) |-> low_q >= MIN_LOW_CYC);
  a_r4_read_count: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_start) |-> (done_nbytes >= 3'd2 && done_nbytes <= 3'd4));
  a_r6_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status != 2'b01);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> done);
  a_r8_busy_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n |-> busy);
  a_r9_free_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (done && TRIGGERED == 0) |-> !done_start);
endmodule

bind spi_sensor_host spi_sensor_host_chk #(.MIN_LOW_CYC(MIN_LOW_CYC), .TRIGGERED(TRIGGERED)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .busy(busy), .done(done),
  .done_start(done_start), .done_nbytes(done_nbytes), .status(status)
);

// File: tb/spi_sensor_host_bench.sv
`timescale 1ns/100ps
module spi_sensor_model #(parameter int D = 2) (
  input  logic        clk,
  input  logic        clr,
  input  logic        sclk,
  input  logic        ss_n,
  input  logic [31:0] pattern,
  output logic        miso,
  output int          low_cnt,
  output int          rise_cnt,
  output int          bad_half
);
  int idx = 0;
  int hr = 0;
  logic prev = 1'b0;
  always @(posedge ss_n or negedge sclk) begin
    if (ss_n) idx <= 0;
    else      idx <= idx + 1;
  end
  assign miso = (!ss_n && idx < 32) ? pattern[31 - idx] : 1'b0;
  initial begin low_cnt = 0; rise_cnt = 0; bad_half = 0; end
  always @(negedge clk) begin
    if (clr) begin
      low_cnt <= 0; rise_cnt <= 0; bad_half <= 0; hr <= 0;
    end else begin
      if (!ss_n) low_cnt <= low_cnt + 1;
      if (sclk && !prev) rise_cnt <= rise_cnt + 1;
      if (sclk) hr <= hr + 1;
      else begin
        if (hr != 0 && hr != D) bad_half <= bad_half + 1;
        hr <= 0;
      end
    end
    prev <= sclk;
  end
endmodule

module spi_sensor_host_bench;
  localparam int TD = 2, TMIN = 40, FD = 3, FMIN = 10;
  logic clk = 0, rst_n = 0, clr = 0;
  logic t_v = 0, f_v = 0, req_start = 0;
  logic [1:0] req_len = 0;
  logic [31:0] t_pat = 0, f_pat = 0;
  int tests = 0, fails = 0;

  logic t_busy, t_done, t_ds, t_sclk, t_ss, t_miso;
  logic [2:0] t_nb; logic [31:0] t_rd; logic [1:0] t_st;
  logic f_busy, f_done, f_ds, f_sclk, f_ss, f_miso;
  logic [2:0] f_nb; logic [31:0] f_rd; logic [1:0] f_st;
  int t_low, t_rise, t_bad, f_low, f_rise, f_bad;

  always #2.5 clk = ~clk;

  spi_sensor_host #(.CLK_DIV(TD), .MIN_LOW_CYC(TMIN), .TRIGGERED(1)) u_spi_sensor_host (
    .clk(clk), .rst_n(rst_n), .req_valid(t_v), .req_start(req_start), .req_len(req_len),
    .busy(t_busy), .done(t_done), .done_start(t_ds), .done_nbytes(t_nb), .rd_data(t_rd),
    .status(t_st), .sclk(t_sclk), .ss_n(t_ss), .miso(t_miso));
  spi_sensor_host #(.CLK_DIV(FD), .MIN_LOW_CYC(FMIN), .TRIGGERED(0)) u_free (
    .clk(clk), .rst_n(rst_n), .req_valid(f_v), .req_start(req_start), .req_len(req_len),
    .busy(f_busy), .done(f_done), .done_start(f_ds), .done_nbytes(f_nb), .rd_data(f_rd),
    .status(f_st), .sclk(f_sclk), .ss_n(f_ss), .miso(f_miso));
  spi_sensor_model #(.D(TD)) u_tsens (.clk(clk), .clr(clr), .sclk(t_sclk), .ss_n(t_ss),
    .pattern(t_pat), .miso(t_miso), .low_cnt(t_low), .rise_cnt(t_rise), .bad_half(t_bad));
  spi_sensor_model #(.D(FD)) u_fsens (.clk(clk), .clr(clr), .sclk(f_sclk), .ss_n(f_ss),
    .pattern(f_pat), .miso(f_miso), .low_cnt(f_low), .rise_cnt(f_rise), .bad_half(f_bad));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit fr, input bit st, input logic [1:0] len,
                        input logic [31:0] pat, output bit seen);
    if (fr) f_pat = pat; else t_pat = pat;
    @(posedge clk); #1;
    clr = 1; req_start = st; req_len = len;
    if (fr) f_v = 1; else t_v = 1;
    @(posedge clk); #1;
    clr = 0; f_v = 0; t_v = 0;
    seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (fr ? f_done : t_done) seen = 1;
    end
  endtask

  function automatic int nbytes_of(input logic [1:0] len);
    return (len == 0) ? 2 : (len == 1) ? 3 : 4;
  endfunction

  task automatic check_read(input bit fr, input logic [1:0] len, input logic [31:0] pat);
    bit seen;
    int n;
    logic [31:0] exp;
    logic [1:0] es;
    run_op(fr, 1'b0, len, pat, seen);
    n = nbytes_of(len);
    exp = pat & (32'hFFFF_FFFF << (8 * (4 - n)));
    es = (pat[31:30] == 2'b01) ? 2'b11 : pat[31:30];
    chk(seen, "R7 read done", 32'(seen), 1);
    chk((fr ? f_nb : t_nb) == 3'(n), "R4 byte count", 32'(fr ? f_nb : t_nb), 32'(n));
    chk((fr ? f_ds : t_ds) == 1'b0, "R4 done_start low", 32'(fr ? f_ds : t_ds), 0);
    chk((fr ? f_rd : t_rd) == exp, "R5 aligned data", fr ? f_rd : t_rd, exp);
    chk((fr ? f_st : t_st) == es, "R6 status decode", 32'(fr ? f_st : t_st), 32'(es));
    chk((fr ? f_rise : t_rise) == 8 * n, "R2 rising edges", 32'(fr ? f_rise : t_rise), 32'(8 * n));
    chk((fr ? f_bad : t_bad) == 0, "R2 half period", 32'(fr ? f_bad : t_bad), 0);
  endtask

  initial begin
    bit seen;
    logic [31:0] keep;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(t_ss && !t_sclk && !t_busy && !t_done, "R1 reset idle",
        {t_ss, t_sclk, t_busy, t_done}, 32'b1000);
    chk(f_ss && !f_sclk && !f_busy && !f_done, "R1 reset idle free",
        {f_ss, f_sclk, f_busy, f_done}, 32'b1000);

    run_op(1'b0, 1'b1, 2'b00, 32'hA5A5_A5A5, seen);
    chk(seen, "R3 start done", 32'(seen), 1);
    chk(t_low == TMIN, "R3 min low time", t_low, TMIN);
    chk(t_ds == 1'b1 && t_nb == 3'd1, "R3 start flags", {t_ds, t_nb}, 32'b1001);
    chk(t_rise == 8, "R3 dummy byte edges", t_rise, 8);
    chk(t_rd == 32'h0, "R3 rd_data kept", t_rd, 0);

    for (int s = 0; s < 4; s++)
      for (int l = 0; l < 4; l++)
        check_read(1'b0, 2'(l), {2'(s), 30'(32'h1234_5678 * (s * 4 + l + 1))});

    keep = t_rd;
    run_op(1'b0, 1'b1, 2'b00, 32'h0F0F_0F0F, seen);
    chk(t_rd == keep, "R3 rd_data unchanged after start", t_rd, keep);
    chk(t_low == TMIN, "R3 second start low time", t_low, TMIN);

    @(negedge clk);
    chk(t_ss && !t_sclk && !t_busy, "R1 idle between ops", {t_ss, t_sclk, t_busy}, 32'b100);

    t_pat = 32'h8123_4567;
    @(posedge clk); #1;
    clr = 1; req_start = 0; req_len = 2'b00; t_v = 1;
    @(posedge clk); #1;
    clr = 0; t_v = 0;
    repeat (5) @(posedge clk);
    #1 req_len = 2'b10; t_v = 1;
    @(posedge clk); #1 t_v = 0;
    chk(t_busy, "R8 busy during transfer", 32'(t_busy), 1);
    seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (t_done) seen = 1;
    end
    chk(t_nb == 3'd2, "R8 second request dropped", t_nb, 2);
    repeat (100) @(negedge clk);
    chk(t_rise == 16, "R8 no extra bus activity", t_rise, 16);

    run_op(1'b1, 1'b1, 2'b00, 32'hFFFF_FFFF, seen);
    chk(!seen, "R9 free start no done", 32'(seen), 0);
    chk(f_low == 0, "R9 free start no select", f_low, 0);
    check_read(1'b1, 2'b01, 32'h4ABC_DEF1);
    check_read(1'b1, 2'b10, 32'h8765_4321);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule